// File: doc/BRIEF.md
# Real-Time Clock Seconds and Alarm Register Bank

This block is the register side of a real-time clock. A separate tick generator supplies a strobe once per second. The block keeps a 32-bit seconds count, compares it against an alarm value, and raises two level interrupts: one for each second and one for the alarm. Software reaches every register over a simple word bus. A write strobe stores data in the same cycle. A read strobe returns data on the following cycle.

A seconds value that software writes does not go straight into the running count. It is held as a pending load and is copied into the count at the next second strobe. Until that strobe, software can read the written value back from a separate location. Software can therefore tell whether its new time has taken effect yet. The block also counts clock cycles since the last strobe, stores a calibration word, and keeps two control bits as plain storage.

Top module: `rtc_regbank`

## Requirements
- R1: After reset every register reads 0, both interrupt outputs are low, and the read data bus is 0.
- R2: A write to offset 0x00 does not change the running count (offset 0x10). The value is copied into the count at the next strobe that comes after the write cycle. A write in the same cycle as a strobe takes effect at the following strobe, and that strobe follows the rule in force before the write.
- R3: Offset 0x04 returns the last value written to offset 0x00.
- R4: A strobe with no pending load increments the running count by one, wrapping from 0xFFFFFFFF to 0. The count does not change without a strobe.
- R5: Status bit 0 at offset 0x20 is set by every strobe. Writing 1 to a status bit clears it, and writing 0 has no effect. A set in the same cycle as a clear leaves the bit set.
- R6: Status bit 1 at offset 0x20 is set at a strobe when the value the count takes at that strobe equals the alarm register (offset 0x18, read/write). The alarm value used is the one held before that cycle.
- R7: Writing 1s to offset 0x28 enables those interrupts (bit 0 seconds, bit 1 alarm). Writing 1s to offset 0x2C disables them. Offset 0x24 reads the enable bits, and writes to 0x24 are ignored.
- R8: `irq_sec` equals status bit 0 AND enable bit 0, and `irq_alarm` equals status bit 1 AND enable bit 1. Both are levels and take their new value in the same cycle as the registers they follow.
- R9: Offset 0x40 stores bits 31 and 24 only. All other bits read 0.
- R10: A write to offset 0x08 stores its low 21 bits, which read back at offset 0x0C. The same write clears the cycle counter.
- R11: Offset 0x14 returns the number of clock cycles since the last strobe or calibration write. It saturates at 65535.
- R12: Read data appears the cycle after a read strobe. Read data is 0 in cycles with no read and for unmapped offsets. Writes to read-only offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse per second from the tick generator |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_sec | output | 1 | Seconds interrupt level |
| irq_alarm | output | 1 | Alarm interrupt level |

## Verification
The assertions check the following on every cycle:
- a pending load is taken at a strobe, or the count increments or holds;
- each event sets its status bit;
- no interrupt is high without both its status and enable bits;
- the cycle counter holds at saturation;
- read data is 0 after a cycle with no read.

Only the bench scenarios can show the following:
- the same-cycle races (a write coinciding with a strobe, a clear coinciding with a set);
- the alarm match across the wrap to zero;
- the masking of control and calibration bits;
- the values read back after an exact count of cycles.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned OFS_SETW  = 'h00;
  localparam int unsigned OFS_SETR  = 'h04;
  localparam int unsigned OFS_CALW  = 'h08;
  localparam int unsigned OFS_CALR  = 'h0C;
  localparam int unsigned OFS_CUR   = 'h10;
  localparam int unsigned OFS_TICK  = 'h14;
  localparam int unsigned OFS_ALM   = 'h18;
  localparam int unsigned OFS_STS   = 'h20;
  localparam int unsigned OFS_MASK  = 'h24;
  localparam int unsigned OFS_EN    = 'h28;
  localparam int unsigned OFS_DIS   = 'h2C;
  localparam int unsigned OFS_CTRL  = 'h40;

  localparam int unsigned NUM_EVT   = 2;
  localparam int unsigned EVT_SEC   = 0;
  localparam int unsigned EVT_ALM   = 1;

  localparam int unsigned CTL_BATT  = 31;
  localparam int unsigned CTL_OSC   = 24;

  typedef enum logic [1:0] {
    LD_HOLD = 2'd0,
    LD_INC  = 2'd1,
    LD_SET  = 2'd2
  } load_sel_e;
endpackage

// File: rtl/rtc_tick_count.sv
module rtc_tick_count #(
  parameter int unsigned TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  output logic [TICK_W-1:0] cnt
);
  localparam logic [TICK_W-1:0] CNT_MAX = '1;

  logic [TICK_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)           cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

  // R11
  tick_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && !clr) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
#(
  parameter int unsigned TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic              set_wr,
  input  logic [TIME_W-1:0] set_data,
  input  logic              alm_wr,
  input  logic [TIME_W-1:0] alm_data,
  output logic [TIME_W-1:0] cur_time,
  output logic [TIME_W-1:0] set_time,
  output logic [TIME_W-1:0] alm_time,
  output logic              sec_evt,
  output logic              alm_evt
);
  logic [TIME_W-1:0] cur_q, setv_q, alm_q, cur_d;
  logic              pend_q;
  load_sel_e         sel;

  always_comb begin
    if (!sec_tick)   sel = LD_HOLD;
    else if (pend_q) sel = LD_SET;
    else             sel = LD_INC;
    case (sel)
      LD_SET:  cur_d = setv_q;
      LD_INC:  cur_d = cur_q + 1'b1;
      default: cur_d = cur_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      setv_q <= '0;
      alm_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cur_q <= cur_d;
      if (set_wr) begin
        setv_q <= set_data;
        pend_q <= 1'b1;
      end else if (sel == LD_SET) begin
        pend_q <= 1'b0;
      end
      if (alm_wr) alm_q <= alm_data;
    end
  end

  assign cur_time = cur_q;
  assign set_time = setv_q;
  assign alm_time = alm_q;
  assign sec_evt  = sec_tick;
  assign alm_evt  = sec_tick && (cur_d == alm_q);

  // R2
  pend_load_chk: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && pend_q) |=> (cur_q == $past(setv_q)));
  // R4
  inc_chk: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && !pend_q) |=> (cur_q == $past(cur_q) + 1'b1));
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sec_tick |=> $stable(cur_q));
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic         clr_wr,
  input  logic         en_wr,
  input  logic         dis_wr,
  input  logic [N-1:0] wmask,
  output logic [N-1:0] sts,
  output logic [N-1:0] en,
  output logic [N-1:0] irq
);
  logic [N-1:0] sts_q, en_q, irq_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic sts_d, en_d;

    always_comb begin
      sts_d = (sts_q[i] && !(clr_wr && wmask[i])) || evt[i];
      if (en_wr && wmask[i])       en_d = 1'b1;
      else if (dis_wr && wmask[i]) en_d = 1'b0;
      else                         en_d = en_q[i];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        sts_q[i] <= 1'b0;
        en_q[i]  <= 1'b0;
        irq_q[i] <= 1'b0;
      end else begin
        sts_q[i] <= sts_d;
        en_q[i]  <= en_d;
        irq_q[i] <= sts_d && en_d;
      end
    end

    // R5
    evt_set_chk: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> sts_q[i]);
    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
      irq_q[i] |-> (sts_q[i] && en_q[i]));
  end

  assign sts = sts_q;
  assign en  = en_q;
  assign irq = irq_q;
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned TIME_W = 32,
  parameter int unsigned TICK_W = 16,
  parameter int unsigned CAL_W  = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_sec,
  output logic              irq_alarm
);
  localparam int unsigned DATA_W = 32;

  logic [TIME_W-1:0]  cur_time, set_time, alm_time;
  logic [TICK_W-1:0]  tick_cnt;
  logic [NUM_EVT-1:0] evt, sts, en, irq;
  logic               sec_evt, alm_evt;
  logic [CAL_W-1:0]   cal_q;
  logic               batt_q, osc_q;
  logic [DATA_W-1:0]  rd_mux, rdata_q;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  logic wr_set, wr_cal, wr_alm, wr_sts, wr_en, wr_dis, wr_ctl;
  assign wr_set = bus_wr && hit(bus_addr, OFS_SETW);
  assign wr_cal = bus_wr && hit(bus_addr, OFS_CALW);
  assign wr_alm = bus_wr && hit(bus_addr, OFS_ALM);
  assign wr_sts = bus_wr && hit(bus_addr, OFS_STS);
  assign wr_en  = bus_wr && hit(bus_addr, OFS_EN);
  assign wr_dis = bus_wr && hit(bus_addr, OFS_DIS);
  assign wr_ctl = bus_wr && hit(bus_addr, OFS_CTRL);

  rtc_time_core #(.TIME_W(TIME_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .sec_tick (sec_tick),
    .set_wr   (wr_set),
    .set_data (bus_wdata[TIME_W-1:0]),
    .alm_wr   (wr_alm),
    .alm_data (bus_wdata[TIME_W-1:0]),
    .cur_time (cur_time),
    .set_time (set_time),
    .alm_time (alm_time),
    .sec_evt  (sec_evt),
    .alm_evt  (alm_evt)
  );

  rtc_tick_count #(.TICK_W(TICK_W)) u_tick (
    .clk (clk),
    .rst (rst),
    .clr (sec_tick || wr_cal),
    .cnt (tick_cnt)
  );

  always_comb begin
    evt          = '0;
    evt[EVT_SEC] = sec_evt;
    evt[EVT_ALM] = alm_evt;
  end

  rtc_irq_ctrl #(.N(NUM_EVT)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .evt    (evt),
    .clr_wr (wr_sts),
    .en_wr  (wr_en),
    .dis_wr (wr_dis),
    .wmask  (bus_wdata[NUM_EVT-1:0]),
    .sts    (sts),
    .en     (en),
    .irq    (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cal_q  <= '0;
      batt_q <= 1'b0;
      osc_q  <= 1'b0;
    end else begin
      if (wr_cal) cal_q <= bus_wdata[CAL_W-1:0];
      if (wr_ctl) begin
        batt_q <= bus_wdata[CTL_BATT];
        osc_q  <= bus_wdata[CTL_OSC];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit(bus_addr, OFS_SETR))      rd_mux = DATA_W'(set_time);
    else if (hit(bus_addr, OFS_CALR)) rd_mux = DATA_W'(cal_q);
    else if (hit(bus_addr, OFS_CUR))  rd_mux = DATA_W'(cur_time);
    else if (hit(bus_addr, OFS_TICK)) rd_mux = DATA_W'(tick_cnt);
    else if (hit(bus_addr, OFS_ALM))  rd_mux = DATA_W'(alm_time);
    else if (hit(bus_addr, OFS_STS))  rd_mux = DATA_W'(sts);
    else if (hit(bus_addr, OFS_MASK)) rd_mux = DATA_W'(en);
    else if (hit(bus_addr, OFS_CTRL)) begin
      rd_mux[CTL_BATT] = batt_q;
      rd_mux[CTL_OSC]  = osc_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
    else             rdata_q <= '0;
  end

  assign bus_rdata = rdata_q;
  assign irq_sec   = irq[EVT_SEC];
  assign irq_alarm = irq[EVT_ALM];

  // R12
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

// File: tb/rtc_regbank_bench.sv
module rtc_regbank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sec_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_sec, irq_alarm;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;
  bit live = 0;

  always #2.5 clk = ~clk;

  rtc_regbank u_rtc_regbank (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_sec(irq_sec), .irq_alarm(irq_alarm)
  );

  // Behavioural reference state
  logic [31:0] m_cur, m_set, m_alm, m_cal, m_ctl, m_rdata;
  logic [1:0]  m_sts, m_en;
  bit          m_pend;
  int          m_tick;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h04: return m_set;
      8'h0C: return m_cal;
      8'h10: return m_cur;
      8'h14: return 32'(m_tick);
      8'h18: return m_alm;
      8'h20: return {30'd0, m_sts};
      8'h24: return {30'd0, m_en};
      8'h40: return m_ctl;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cur = 0; m_set = 0; m_alm = 0; m_cal = 0; m_ctl = 0; m_rdata = 0;
      m_sts = 0; m_en = 0; m_pend = 0; m_tick = 0;
    end else begin
      logic [31:0] nxt;
      bit w;
      w = bus_wr;
      m_rdata = bus_rd ? m_read(bus_addr) : 32'd0;
      nxt = m_cur;
      if (sec_tick) begin
        if (m_pend) begin nxt = m_set; m_pend = 0; end
        else nxt = m_cur + 1;
      end
      if (w && bus_addr == 8'h20) m_sts = m_sts & ~bus_wdata[1:0];
      if (sec_tick) m_sts[0] = 1'b1;
      if (sec_tick && nxt == m_alm) m_sts[1] = 1'b1;
      m_cur = nxt;
      if (sec_tick || (w && bus_addr == 8'h08)) m_tick = 0;
      else if (m_tick < 65535) m_tick++;
      if (w) begin
        case (bus_addr)
          8'h00: begin m_set = bus_wdata; m_pend = 1; end
          8'h08: m_cal = bus_wdata & 32'h001F_FFFF;
          8'h18: m_alm = bus_wdata;
          8'h28: m_en = m_en | bus_wdata[1:0];
          8'h2C: m_en = m_en & ~bus_wdata[1:0];
          8'h40: m_ctl = bus_wdata & 32'h8100_0000;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Every-cycle comparison against the model (R8 irq levels, R12 read data)
  always @(negedge clk) begin
    if (live && !rst) begin
      check("R8 irq_sec", {31'd0, irq_sec}, {31'd0, m_sts[0] & m_en[0]});
      check("R8 irq_alarm", {31'd0, irq_alarm}, {31'd0, m_sts[1] & m_en[1]});
      check("R12 rdata", bus_rdata, m_rdata);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<190000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit tk = 0);
    bus_wr = 1; bus_addr = a; bus_wdata = d; sec_tick = tk;
    @(negedge clk);
    bus_wr = 0; sec_tick = 0;
  endtask

  task automatic strobe();
    sec_tick = 1;
    @(negedge clk);
    sec_tick = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    logic [31:0] t;
    repeat (3) @(negedge clk);
    check("R1 irq_sec", {31'd0, irq_sec}, 32'd0);
    check("R1 irq_alarm", {31'd0, irq_alarm}, 32'd0);
    check("R1 rdata", bus_rdata, 32'd0);
    rst = 0;
    live = 1;
    rd(8'h10, 0, "R1 cur");
    rd(8'h20, 0, "R1 sts");
    rd(8'h24, 0, "R1 mask");
    rd(8'h40, 0, "R1 ctrl");

    // R2 / R3 / R4: deferred load and increment
    wr(8'h00, 32'd100);
    rd(8'h10, 0, "R2 not yet loaded");
    rd(8'h04, 100, "R3 readback");
    strobe();
    rd(8'h10, 100, "R2 loaded at strobe");
    strobe();
    rd(8'h10, 101, "R4 increment");
    rd(8'h04, 100, "R3 readback kept");
    idle(4);
    rd(8'h10, 101, "R4 holds without strobe");

    // R5: status clear rules
    rd(8'h20, 1, "R5 sec status set");
    wr(8'h20, 0);
    rd(8'h20, 1, "R5 write 0 no effect");
    wr(8'h20, 1);
    rd(8'h20, 0, "R5 write 1 clears");
    wr(8'h20, 1, 1);
    rd(8'h20, 1, "R5 set wins over clear");

    // R7 / R8: enable, disable, mask
    wr(8'h28, 1);
    rd(8'h24, 1, "R7 enable");
    check("R8 irq_sec high", {31'd0, irq_sec}, 1);
    wr(8'h20, 1);
    check("R8 irq_sec low after clear", {31'd0, irq_sec}, 0);
    wr(8'h24, 3);
    rd(8'h24, 1, "R7 mask write ignored");
    wr(8'h2C, 1);
    rd(8'h24, 0, "R7 disable");

    // R6: alarm match
    t = m_cur + 2;
    wr(8'h18, t);
    rd(8'h18, t, "R6 alarm readback");
    wr(8'h28, 2);
    strobe();
    check("R6 no alarm yet", {31'd0, irq_alarm}, 0);
    strobe();
    check("R6 alarm irq", {31'd0, irq_alarm}, 1);
    rd(8'h20, 3, "R6 alarm status");
    wr(8'h20, 2);
    rd(8'h20, 1, "R6 alarm cleared");
    check("R8 irq_alarm low", {31'd0, irq_alarm}, 0);

    // R4 wrap, R6 alarm at zero
    wr(8'h00, 32'hFFFF_FFFF);
    strobe();
    rd(8'h10, 32'hFFFF_FFFF, "R4 top value");
    wr(8'h18, 0);
    strobe();
    rd(8'h10, 0, "R4 wrap");
    rd(8'h20, 3, "R6 alarm at wrap");
    check("R6 irq at wrap", {31'd0, irq_alarm}, 1);

    // R2: write coinciding with strobe, no pending
    wr(8'h00, 32'd500, 1);
    rd(8'h10, 1, "R2 same-cycle write increments");
    strobe();
    rd(8'h10, 500, "R2 loads next strobe");

    // R9
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, 32'h8100_0000, "R9 ctrl bits");
    wr(8'h40, 0);
    rd(8'h40, 0, "R9 ctrl clear");

    // R10
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h001F_FFFF, "R10 cal mask");
    idle(7);
    wr(8'h08, 32'h0019_8233);
    rd(8'h14, 0, "R10 cal clears tick");

    // R11
    strobe();
    idle(5);
    rd(8'h14, 5, "R11 tick count");
    idle(65540);
    rd(8'h14, 65535, "R11 tick saturates");

    // R12
    rd(8'h3C, 0, "R12 unmapped");
    t = m_cur;
    wr(8'h10, 32'd1234);
    rd(8'h10, t, "R12 read-only write ignored");
    idle(1);
    check("R12 rdata idle", bus_rdata, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule